// File: doc/BRIEF.md
# Multi-port I2C hub repeater core

This core is a sampled, digital model of a five-port bidirectional I2C hub. Each port has an open-drain pad, seen as a pad input and an active-high pull-low enable. Port 0 always takes part in the hub. Ports 1 to 4 each take part only while their own active-high enable is set. A low that an outside device drives on any active port is repeated onto every other active port. SDA and SCL use two copies of the same lane logic and have no state in common.

Hubs join into a larger cluster through two open-drain expansion lines per signal, wire-ANDed across hubs:

- The **any-low** line is low while any hub sees a low.
- The **held** line is low only while some port in the cluster is held low by an outside driver.

Each hub tells its own lows apart from outside lows. It compares every synchronized pad input with its own drive, delayed by the same number of stages. This keeps the hub from latching the bus low on its own repeated lows.

When the outside drivers let go, the hub releases the bus in a fixed order:

1. The port that was released last stays driven by the hub until the held line is seen high.
2. That port is then freed.
3. The any-low line is released once that port reads high, or once a timeout in clock cycles has run out, whichever comes first.
4. The remaining ports are freed only after the any-low line is seen high.

Pad and expansion inputs pass through two-flop synchronizers. All outputs are registered.

Top module: `i2c_hub_repeater`

## Requirements
- R1: While reset is asserted and right after it, no pad pull-low and no expansion pull-low is asserted.
- R2: A port whose enable is clear (port k uses enable bit k-1) is never pulled low by the hub, and a low on it causes no expansion or repeat activity.
- R3: An outside low on an active port makes the hub assert its any-low pull-low.
- R4: The hub asserts its held pull-low only for a low that an outside driver holds on an active port. Lows the hub drives itself, including those repeated from the cluster's any-low line, never assert it, and the held pull-low is never asserted without the any-low pull-low.
- R5: While the synchronized any-low line is low, every active port that is not held low from outside is pulled low by the hub.
- R6: When the last outside driver lets go, the hub pulls that port low until the held line is seen high, and then releases it.
- R7: The hub releases its any-low pull-low only after the held line has been seen high.
- R8: The other ports are released only after the any-low line is seen high, and afterwards every pull-low is inactive.
- R9: The any-low pull-low is released as soon as the last port reads high, or after REL_TMO cycles if that port is still rising.
- R10: While a port is still held low from outside after another port was released, the held pull-low stays asserted and the released port is repeated low.
- R11: The SDA and SCL lanes are independent: activity on one lane drives nothing on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | NP-1 | Active-high enables for ports 1..NP-1 (bit k-1 enables port k) |
| sda_pad_in | input | NP | Sensed SDA level of each port |
| sda_pad_oe | output | NP | SDA pull-low enable of each port |
| scl_pad_in | input | NP | Sensed SCL level of each port |
| scl_pad_oe | output | NP | SCL pull-low enable of each port |
| sda_xa_in | input | 1 | Sensed SDA any-low expansion line |
| sda_xa_oe | output | 1 | Pull-low of the SDA any-low expansion line |
| sda_xh_in | input | 1 | Sensed SDA held expansion line |
| sda_xh_oe | output | 1 | Pull-low of the SDA held expansion line |
| scl_xa_in | input | 1 | Sensed SCL any-low expansion line |
| scl_xa_oe | output | 1 | Pull-low of the SCL any-low expansion line |
| scl_xh_in | input | 1 | Sensed SCL held expansion line |
| scl_xh_oe | output | 1 | Pull-low of the SCL held expansion line |

## Verification
The bench builds the core with NP=5 and SYNC=2, and shortens REL_TMO to 6 cycles. The slow-rise case can then be reached by holding the last port low for 14 cycles after the hub frees it, so the timeout path and the port-high path of the any-low release are both exercised. The bench can also pull the any-low line low on its own, acting as a second hub in the cluster. This reaches the case where the hub only repeats and must keep its held line released.

// File: rtl/hub_pkg.sv
package hub_pkg;
  // Lane sequencer states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // bus idle, nothing driven
    ST_BUSY = 2'd1,  // a low is present, repeating
    ST_REL  = 2'd2,  // held line high, last port freed, timing its rise
    ST_WAIT = 2'd3   // any-low released, waiting for the cluster
  } hub_st_e;
endpackage

// File: rtl/hub_sync.sv
module hub_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned DEPTH   = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/hub_lane.sv
module hub_lane
  import hub_pkg::*;
#(
  parameter int unsigned NP      = 5,
  parameter int unsigned SYNC    = 2,
  parameter int unsigned REL_TMO = 125
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] act,
  input  logic [NP-1:0] pad_in,
  input  logic          xa_in,
  input  logic          xh_in,
  output logic [NP-1:0] pad_oe,
  output logic          xa_oe,
  output logic          xh_oe
);
  localparam int unsigned CW = $clog2(REL_TMO + 1);

  logic [NP+1:0] raw_s;
  logic [NP-1:0] p, drv_echo;
  logic          xa_s, xh_s;

  hub_sync #(.W(NP+2), .DEPTH(SYNC), .RST_VAL(1'b1)) u_in (
    .clk(clk), .rst(rst), .d({xh_in, xa_in, pad_in}), .q(raw_s));
  // own drive delayed like the pad path, to mask our own lows
  hub_sync #(.W(NP), .DEPTH(SYNC), .RST_VAL(1'b0)) u_echo (
    .clk(clk), .rst(rst), .d(pad_oe), .q(drv_echo));

  assign p    = raw_s[NP-1:0];
  assign xa_s = raw_s[NP];
  assign xh_s = raw_s[NP+1];

  hub_st_e       st, st_n;
  logic          own, own_n, xh_seen, xh_seen_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [NP-1:0] last_q, last_n, ext_prev, ext_live, fell, rel_mask, rel_mask_n, drv_n;
  logic          last_rise, any_ext;

  assign rel_mask  = (st == ST_REL || st == ST_WAIT) ? last_q : '0;
  assign ext_live  = act & ~p & ~drv_echo & ~rel_mask;
  assign any_ext   = |ext_live;
  assign fell      = ext_prev & ~ext_live;
  assign last_rise = |(last_q & p & ~drv_echo);

  always_comb begin
    st_n      = st;
    own_n     = own;
    xh_seen_n = xh_seen;
    cnt_n     = cnt;
    last_n    = (|fell) ? (fell & (~fell + NP'(1))) : last_q;
    case (st)
      ST_IDLE: begin
        if (any_ext || !xa_s) begin
          st_n      = ST_BUSY;
          own_n     = any_ext;
          xh_seen_n = 1'b0;
        end
      end
      ST_BUSY: begin
        if (any_ext) own_n = 1'b1;
        if (!xh_s) xh_seen_n = 1'b1;
        if (own && xh_seen && xh_s && !any_ext) begin
          st_n  = ST_REL;
          cnt_n = '0;
        end else if (!own && !any_ext && xa_s) begin
          st_n = ST_IDLE;
        end
      end
      ST_REL: begin
        cnt_n = cnt + CW'(1);
        if (any_ext) begin
          st_n      = ST_BUSY;
          xh_seen_n = 1'b0;
        end else if (last_rise || cnt == CW'(REL_TMO - 1)) begin
          st_n = ST_WAIT;
        end
      end
      default: begin
        if (xa_s && (last_q == '0 || last_rise)) begin
          st_n  = ST_IDLE;
          own_n = 1'b0;
        end
      end
    endcase
    rel_mask_n = (st_n == ST_REL || st_n == ST_WAIT) ? last_n : '0;
    drv_n      = (st_n == ST_IDLE) ? '0 : (act & ~ext_live & ~{NP{xa_s}} & ~rel_mask_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      own      <= 1'b0;
      xh_seen  <= 1'b0;
      cnt      <= '0;
      last_q   <= '0;
      ext_prev <= '0;
      pad_oe   <= '0;
      xa_oe    <= 1'b0;
      xh_oe    <= 1'b0;
    end else begin
      st       <= st_n;
      own      <= own_n;
      xh_seen  <= xh_seen_n;
      cnt      <= cnt_n;
      last_q   <= last_n;
      ext_prev <= ext_live;
      pad_oe   <= drv_n;
      xa_oe    <= own_n && (st_n == ST_BUSY || st_n == ST_REL);
      xh_oe    <= (st_n != ST_WAIT) && any_ext;
    end
  end
endmodule

// File: rtl/i2c_hub_repeater.sv
module i2c_hub_repeater #(
  parameter int unsigned NP      = 5,
  parameter int unsigned SYNC    = 2,
  parameter int unsigned REL_TMO = 125
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-2:0] port_en,
  input  logic [NP-1:0] sda_pad_in,
  output logic [NP-1:0] sda_pad_oe,
  input  logic [NP-1:0] scl_pad_in,
  output logic [NP-1:0] scl_pad_oe,
  input  logic          sda_xa_in,
  output logic          sda_xa_oe,
  input  logic          sda_xh_in,
  output logic          sda_xh_oe,
  input  logic          scl_xa_in,
  output logic          scl_xa_oe,
  input  logic          scl_xh_in,
  output logic          scl_xh_oe
);
  logic [NP-2:0] en_s;
  logic [NP-1:0] act;

  hub_sync #(.W(NP-1), .DEPTH(SYNC), .RST_VAL(1'b0)) u_en (
    .clk(clk), .rst(rst), .d(port_en), .q(en_s));

  assign act = {en_s, 1'b1};  // port 0 always active

  hub_lane #(.NP(NP), .SYNC(SYNC), .REL_TMO(REL_TMO)) u_sda (
    .clk(clk), .rst(rst), .act(act), .pad_in(sda_pad_in),
    .xa_in(sda_xa_in), .xh_in(sda_xh_in),
    .pad_oe(sda_pad_oe), .xa_oe(sda_xa_oe), .xh_oe(sda_xh_oe));

  hub_lane #(.NP(NP), .SYNC(SYNC), .REL_TMO(REL_TMO)) u_scl (
    .clk(clk), .rst(rst), .act(act), .pad_in(scl_pad_in),
    .xa_in(scl_xa_in), .xh_in(scl_xh_in),
    .pad_oe(scl_pad_oe), .xa_oe(scl_xa_oe), .xh_oe(scl_xh_oe));
endmodule

// File: rtl/hub_checks.sv
module hub_checks #(
  parameter int unsigned NP = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [NP-2:0] en_s,
  input logic [NP-1:0] sda_pad_oe,
  input logic          sda_xa_oe,
  input logic          sda_xh_oe,
  input logic          sda_xa_in,
  input logic          sda_xh_in,
  input logic          scl_xa_oe,
  input logic          scl_xh_oe
);
  for (genvar k = 1; k < NP; k++) begin : g_dis
    p_dis_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      !en_s[k-1] |=> !sda_pad_oe[k]);
  end

  p_xh_implies_xa_r4: assert property (@(posedge clk) disable iff (rst)
    sda_xh_oe |-> sda_xa_oe);

  p_scl_xh_implies_xa_r4: assert property (@(posedge clk) disable iff (rst)
    scl_xh_oe |-> scl_xa_oe);

  p_xa_after_xh_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_xa_oe) |-> (!sda_xh_oe && $past(sda_xh_in)));

  p_bulk_release_r8: assert property (@(posedge clk) disable iff (rst)
    ($countones($past(sda_pad_oe)) > 1 && sda_pad_oe == '0) |-> $past(sda_xa_in));

  p_hold_last_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_xh_oe) && sda_xa_oe) |-> (sda_pad_oe != '0));
endmodule

bind i2c_hub_repeater hub_checks #(.NP(NP)) u_chk (
  .clk(clk), .rst(rst), .en_s(en_s), .sda_pad_oe(sda_pad_oe),
  .sda_xa_oe(sda_xa_oe), .sda_xh_oe(sda_xh_oe),
  .sda_xa_in(sda_xa_in), .sda_xh_in(sda_xh_in),
  .scl_xa_oe(scl_xa_oe), .scl_xh_oe(scl_xh_oe));

// File: tb/sim_i2c_hub_repeater.sv
`timescale 1ns/1ps
module sim_i2c_hub_repeater;
  localparam int NP = 5;
  localparam int TMO = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic [NP-2:0] port_en;
  logic [NP-1:0] sx, cx;          // outside drivers per port
  logic          bxa;             // another hub pulling SDA any-low
  logic          slow;            // port 4 rises slowly after hub release
  int            hold;
  logic [NP-1:0] sda_pad_in, sda_pad_oe, scl_pad_in, scl_pad_oe;
  logic sda_xa_in, sda_xa_oe, sda_xh_in, sda_xh_oe;
  logic scl_xa_in, scl_xa_oe, scl_xh_in, scl_xh_oe;

  assign sda_pad_in = ~(sda_pad_oe | sx | {(hold > 0), {(NP-1){1'b0}}});
  assign scl_pad_in = ~(scl_pad_oe | cx);
  assign sda_xa_in  = ~(sda_xa_oe | bxa);
  assign sda_xh_in  = ~sda_xh_oe;
  assign scl_xa_in  = ~scl_xa_oe;
  assign scl_xh_in  = ~scl_xh_oe;

  i2c_hub_repeater #(.NP(NP), .SYNC(2), .REL_TMO(TMO)) u0 (
    .clk(clk), .rst(rst), .port_en(port_en),
    .sda_pad_in(sda_pad_in), .sda_pad_oe(sda_pad_oe),
    .scl_pad_in(scl_pad_in), .scl_pad_oe(scl_pad_oe),
    .sda_xa_in(sda_xa_in), .sda_xa_oe(sda_xa_oe),
    .sda_xh_in(sda_xh_in), .sda_xh_oe(sda_xh_oe),
    .scl_xa_in(scl_xa_in), .scl_xa_oe(scl_xa_oe),
    .scl_xh_in(scl_xh_in), .scl_xh_oe(scl_xh_oe));

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [3:0] en_q [$];  // enables as seen by the hub, behavioural delay

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // slow rise model: port 4 stays low for 14 cycles after the hub frees it
  always @(negedge clk) begin
    if (slow && sda_pad_oe[4]) hold <= 14;
    else if (hold > 0) hold <= hold - 1;
  end

  // per-clock reference: a disabled port is never pulled low (R2), held implies any-low (R4)
  always @(negedge clk) begin
    if (!rst && !done) begin
      en_q.push_back(port_en);
      if (en_q.size() > 4) begin
        logic [3:0] e;
        e = en_q.pop_front();
        for (int k = 1; k < NP; k++)
          if (!e[k-1] && en_q[0][k-1] == e[k-1])
            chk(!sda_pad_oe[k] && !scl_pad_oe[k], "R2 disabled port driven", k, 0);
      end
      chk(!(sda_xh_oe && !sda_xa_oe), "R4 held without any-low", sda_xh_oe, 0);
    end
  end

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int txh, txa, tp;
    bit held0, pad_at_xa;
    port_en = 4'hF; sx = '0; cx = '0; bxa = 1'b0; slow = 1'b0; hold = 0;
    cyc(3);
    chk(sda_pad_oe == 0 && scl_pad_oe == 0, "R1 pads in reset", sda_pad_oe, 0);
    chk(!sda_xa_oe && !sda_xh_oe && !scl_xa_oe && !scl_xh_oe, "R1 expansion in reset", sda_xa_oe, 0);
    rst = 1'b0;
    cyc(6);
    chk(sda_pad_oe == 0 && !sda_xa_oe, "R1 idle after reset", sda_pad_oe, 0);

    // outside low on port 0
    sx[0] = 1'b1;
    cyc(12);
    chk(sda_pad_oe == 5'b11110, "R5 repeat to others", sda_pad_oe, 5'b11110);
    chk(sda_xa_oe == 1'b1, "R3 any-low asserted", sda_xa_oe, 1);
    chk(sda_xh_oe == 1'b1, "R4 held asserted for outside low", sda_xh_oe, 1);

    // release: check the ordering
    sx[0] = 1'b0;
    txh = -1; txa = -1; tp = -1; held0 = 0; pad_at_xa = 0;
    for (int c = 1; c <= 80; c++) begin
      @(negedge clk);
      if (sda_pad_oe[0]) held0 = 1;
      if (!sda_xh_oe && txh < 0) txh = c;
      if (!sda_xa_oe && txa < 0) begin txa = c; pad_at_xa = sda_pad_in[0]; end
      if (sda_pad_oe[4:1] == 0 && tp < 0) tp = c;
    end
    chk(held0, "R6 last port held by hub", held0, 1);
    chk(txh < txa, "R7 any-low after held", txa, txh + 1);
    chk(txa < tp, "R8 others after any-low", tp, txa + 1);
    chk(pad_at_xa == 1'b1, "R9 release on port high", pad_at_xa, 1);
    chk(sda_pad_oe == 0 && !sda_xa_oe && !sda_xh_oe, "R8 all idle", sda_pad_oe, 0);

    // disabled port 3
    port_en = 4'b1011;
    cyc(6);
    sx[1] = 1'b1;
    cyc(12);
    chk(sda_pad_oe == 5'b10101, "R2 disabled port not repeated", sda_pad_oe, 5'b10101);
    sx[1] = 1'b0;
    cyc(80);
    chk(sda_pad_oe == 0 && !sda_xa_oe, "R8 idle after disabled case", sda_pad_oe, 0);
    sx[3] = 1'b1;
    cyc(12);
    chk(!sda_xa_oe && !sda_xh_oe && sda_pad_oe == 0, "R2 disabled low ignored", sda_pad_oe, 0);
    sx[3] = 1'b0;
    port_en = 4'hF;
    cyc(8);

    // another hub pulls any-low: repeat only
    bxa = 1'b1;
    cyc(8);
    chk(sda_pad_oe == 5'b11111, "R5 cluster low repeated", sda_pad_oe, 5'b11111);
    chk(!sda_xh_oe && !sda_xa_oe, "R4 own repeat not counted", sda_xh_oe, 0);
    bxa = 1'b0;
    cyc(8);
    chk(sda_pad_oe == 0, "R8 release after cluster high", sda_pad_oe, 0);

    // stretch / arbitration: two outside drivers
    sx[1] = 1'b1; sx[2] = 1'b1;
    cyc(12);
    sx[1] = 1'b0;
    cyc(10);
    chk(sda_xh_oe == 1'b1, "R10 held stays while port 2 low", sda_xh_oe, 1);
    chk(sda_pad_oe[1] == 1'b1, "R10 released port repeated", sda_pad_oe[1], 1);
    sx[2] = 1'b0;
    cyc(80);
    chk(sda_pad_oe == 0 && !sda_xa_oe, "R10 idle after stretch", sda_pad_oe, 0);

    // slow rise on port 4: timeout path
    slow = 1'b1;
    sx[4] = 1'b1;
    cyc(12);
    sx[4] = 1'b0;
    txa = -1; pad_at_xa = 1;
    for (int c = 1; c <= 80; c++) begin
      @(negedge clk);
      if (!sda_xa_oe && txa < 0) begin txa = c; pad_at_xa = sda_pad_in[4]; end
    end
    chk(txa > 0 && pad_at_xa == 1'b0, "R9 timeout release while rising", pad_at_xa, 0);
    chk(sda_pad_oe == 0 && !sda_xa_oe && !sda_xh_oe, "R9 idle after timeout", sda_pad_oe, 0);
    slow = 1'b0;
    cyc(4);

    // SCL lane alone
    cx[2] = 1'b1;
    cyc(12);
    chk(scl_pad_oe == 5'b11011, "R11 scl repeats", scl_pad_oe, 5'b11011);
    chk(scl_xh_oe == 1'b1, "R11 scl held asserted", scl_xh_oe, 1);
    chk(sda_pad_oe == 0 && !sda_xa_oe, "R11 sda untouched", sda_pad_oe, 0);
    cx[2] = 1'b0;
    cyc(80);
    chk(scl_pad_oe == 0 && !scl_xa_oe, "R11 scl idle", scl_pad_oe, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule